// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block fills a bank of bus-interface configuration bytes from a small two-wire serial EEPROM after reset. When reset is released it looks at the levels on the EEPROM clock and data pins. If clock is low and data is high, it treats the EEPROM as not fitted and loads a fixed set of factory values. Otherwise it reads eighteen bytes starting at address 0x00 in a single sequential read transaction. The bytes carry the identification and arbitration values, a check byte, the six-byte burned-in address, its two check bytes and one reserved byte.

While the bytes arrive, an 8-bit CRC is built over the first eight. The CRC is compared with the check byte at position 0x08. A mismatch raises both the device-missing and CRC-error status bits, but the bytes that were read are still loaded. A separate bank of read-only factory values is always presented and is never touched by the load. When loading ends, by either path, a done flag rises and all loaded values are frozen.

Both serial pins are open-drain. Each pin has an input that returns the wired level and a drive-low output.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: If `sclIn` is low and `sdaIn` is high on the first clock edge with `rstN` high, the block drives neither line. On the next edge it loads the factory image, sets `devMissing`, leaves `crcBad` clear and raises `loadDone`, so `loadDone` is high two edges after reset release.
- R2: In every other case the block performs this read transaction:
  - start;
  - byte `{DEV_ADDR,0}` (0xA0 by default), then word address 0x00;
  - repeated start, then byte `{DEV_ADDR,1}`;
  - 18 data bytes read most significant bit first, acknowledged after every byte except the 18th, which gets no acknowledge;
  - stop.

  No byte at address 0x12 or above is ever requested.
- R3: Image byte n (0 to 17) appears on `cfgImage[8n+7:8n]`. The byte roles are:
  - vendor ID low and high at 0–1;
  - device ID low and high at 2–3;
  - revision at 4, sub-class at 5, minimum grant at 6, maximum latency at 7;
  - check byte at 8;
  - burned-in address, most significant byte first, at 9–14;
  - its two check bytes at 15–16;
  - reserved at 17.
- R4: The CRC uses generator 0x07 (x^8+x^2+x+1), starts at 0x00 and runs most significant bit first over bytes 0–7. When it equals byte 8, `devMissing` and `crcBad` stay low after the load.
- R5: When the CRC differs from byte 8, both `devMissing` and `crcBad` are set. All 18 bytes read are still loaded unchanged into `cfgImage`.
- R6: If the addressed device does not acknowledge its address byte, the block issues a stop. It then loads the factory image, sets `devMissing`, leaves `crcBad` clear and raises `loadDone`.
- R7: The factory image is:
  - bytes 0–8: 0x4C, 0x10, 0x08, 0x05, 0x10, 0x80, 0x01, 0x00, 0x7A;
  - bytes 9–16: 0x00;
  - byte 17: 0x01.
- R8: `hwImage` always equals the factory image, whatever is read from the EEPROM.
- R9: Once `loadDone` is high, it stays high until reset. `cfgImage`, `devMissing` and `crcBad` then hold their values, and both drive-low outputs stay low, whatever the serial lines do.
- R10: During reset, `loadDone`, `devMissing` and `crcBad` are low, `cfgImage` is all zero and neither line is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| sclIn | input | 1 | Wired level of the serial clock line |
| sclDrvLow | output | 1 | Pull the serial clock line low |
| sdaIn | input | 1 | Wired level of the serial data line |
| sdaDrvLow | output | 1 | Pull the serial data line low |
| cfgImage | output | 144 | Loaded configuration bytes, byte n at bits 8n+7:8n |
| hwImage | output | 144 | Read-only factory configuration bytes |
| devMissing | output | 1 | No usable EEPROM, or image check failed |
| crcBad | output | 1 | CRC over bytes 0–7 did not match byte 8 |
| loadDone | output | 1 | Loading finished; outputs frozen |

## Verification
The strap decision and the factory load are due exactly two clock edges after reset release. The bench counts those two rising edges and samples `loadDone`, the flags and the image on the following falling edge. Results of a serial read are due only after the whole transaction, so the bench waits for `loadDone`, under a cycle guard, before sampling the image and flags half a clock later. The transaction shape is judged from what the behavioural EEPROM model records on the wire: the word address, the number of bytes handed out, the final no-acknowledge and the stop. Frozen outputs are checked by disturbing the data line after `loadDone` and re-sampling a few cycles later.

// File: rtl/eecfg_pkg.sv
package eecfg_pkg;

  localparam int IMG_BYTES = 18;
  localparam int IDX_W     = $clog2(IMG_BYTES);
  localparam int CRC_POS   = 8;

  typedef enum logic [3:0] {
    ST_STRAP, ST_DEFAULT, ST_START, ST_TXBIT, ST_TXACK,
    ST_RSTART, ST_RXBIT, ST_RXACK, ST_STOP, ST_DONE
  } seqState_t;

  // strobes from the sequencer into the byte datapath
  typedef struct packed {
    logic             loadDefaults;
    logic             shiftIn;
    logic             storeByte;
    logic [IDX_W-1:0] byteIdx;
  } dpCtl_t;

  // one byte through a MSB-first CRC-8 with zero final xor
  function automatic logic [7:0] crcStep(input logic [7:0] crc,
                                         input logic [7:0] data,
                                         input logic [7:0] poly);
    logic [7:0] c;
    c = crc ^ data;
    for (int k = 0; k < 8; k++) begin
      c = c[7] ? ((c << 1) ^ poly) : (c << 1);
    end
    return c;
  endfunction

  function automatic logic [7:0] factoryByte(input int idx);
    case (idx)
      0:  return 8'h4C;
      1:  return 8'h10;
      2:  return 8'h08;
      3:  return 8'h05;
      4:  return 8'h10;
      5:  return 8'h80;
      6:  return 8'h01;
      7:  return 8'h00;
      8:  return 8'h7A;
      17: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/eecfg_ctrl.sv
module eecfg_ctrl
  import eecfg_pkg::*;
#(
  parameter int         QTR_CYCLES = 4,
  parameter logic [6:0] DEV_ADDR   = 7'h50
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclIn,
  input  logic   sdaIn,
  output logic   sclDrvLow,
  output logic   sdaDrvLow,
  output dpCtl_t ctl,
  output logic   loadDone
);

  localparam int TICK_W = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(QTR_CYCLES - 1);
  localparam logic [IDX_W-1:0]  LAST_BYTE = IDX_W'(IMG_BYTES - 1);

  seqState_t         state;
  logic [TICK_W-1:0] tickCnt;
  logic [1:0]        phase;
  logic [2:0]        bitCnt;
  logic [1:0]        txSel;
  logic [IDX_W-1:0]  byteCnt;
  logic              ackBad;
  logic              failNack;
  logic [7:0]        txByte;
  logic              phaseEnd;
  logic              lastPhase;
  logic              serialSt;

  assign serialSt  = (state != ST_STRAP) && (state != ST_DEFAULT) && (state != ST_DONE);
  assign phaseEnd  = serialSt && (tickCnt == TICK_LAST);
  assign lastPhase = phaseEnd && (phase == 2'd3);

  always_comb begin
    case (txSel)
      2'd1:    txByte = 8'h00;
      2'd2:    txByte = {DEV_ADDR, 1'b1};
      default: txByte = {DEV_ADDR, 1'b0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_STRAP;
      tickCnt  <= '0;
      phase    <= '0;
      bitCnt   <= '0;
      txSel    <= '0;
      byteCnt  <= '0;
      ackBad   <= 1'b0;
      failNack <= 1'b0;
    end else begin
      if (serialSt) begin
        if (phaseEnd) begin
          tickCnt <= '0;
          phase   <= phase + 2'd1;
        end else begin
          tickCnt <= tickCnt + TICK_W'(1);
        end
      end
      if (state == ST_TXACK && phaseEnd && phase == 2'd2) ackBad <= sdaIn;
      case (state)
        ST_STRAP:   state <= (!sclIn && sdaIn) ? ST_DEFAULT : ST_START;
        ST_DEFAULT: state <= ST_DONE;
        ST_DONE:    state <= ST_DONE;
        default: begin
          if (lastPhase) begin
            case (state)
              ST_START, ST_RSTART: begin
                state  <= ST_TXBIT;
                bitCnt <= '0;
              end
              ST_TXBIT: begin
                if (bitCnt == 3'd7) state <= ST_TXACK;
                else bitCnt <= bitCnt + 3'd1;
              end
              ST_TXACK: begin
                bitCnt <= '0;
                if (ackBad) begin
                  failNack <= 1'b1;
                  state    <= ST_STOP;
                end else if (txSel == 2'd0) begin
                  txSel <= 2'd1;
                  state <= ST_TXBIT;
                end else if (txSel == 2'd1) begin
                  txSel <= 2'd2;
                  state <= ST_RSTART;
                end else begin
                  byteCnt <= '0;
                  state   <= ST_RXBIT;
                end
              end
              ST_RXBIT: begin
                if (bitCnt == 3'd7) state <= ST_RXACK;
                else bitCnt <= bitCnt + 3'd1;
              end
              ST_RXACK: begin
                if (byteCnt == LAST_BYTE) begin
                  state <= ST_STOP;
                end else begin
                  byteCnt <= byteCnt + IDX_W'(1);
                  bitCnt  <= '0;
                  state   <= ST_RXBIT;
                end
              end
              ST_STOP: state <= failNack ? ST_DEFAULT : ST_DONE;
              default: state <= ST_DONE;
            endcase
          end
        end
      endcase
    end
  end

  // line levels per quarter phase
  always_comb begin
    sclDrvLow = 1'b0;
    sdaDrvLow = 1'b0;
    case (state)
      ST_START, ST_RSTART: begin
        sclDrvLow = (phase == 2'd0) || (phase == 2'd3);
        sdaDrvLow = phase[1];
      end
      ST_TXBIT: begin
        sclDrvLow = (phase == 2'd0) || (phase == 2'd3);
        sdaDrvLow = !txByte[3'd7 - bitCnt];
      end
      ST_TXACK, ST_RXBIT: begin
        sclDrvLow = (phase == 2'd0) || (phase == 2'd3);
      end
      ST_RXACK: begin
        sclDrvLow = (phase == 2'd0) || (phase == 2'd3);
        sdaDrvLow = (byteCnt != LAST_BYTE);
      end
      ST_STOP: begin
        sclDrvLow = (phase == 2'd0);
        sdaDrvLow = !phase[1];
      end
      default: ;
    endcase
  end

  always_comb begin
    ctl.loadDefaults = (state == ST_DEFAULT);
    ctl.shiftIn      = (state == ST_RXBIT) && phaseEnd && (phase == 2'd2);
    ctl.storeByte    = (state == ST_RXACK) && phaseEnd && (phase == 2'd0);
    ctl.byteIdx      = byteCnt;
  end

  assign loadDone = (state == ST_DONE);

endmodule

// File: rtl/eecfg_dp.sv
module eecfg_dp
  import eecfg_pkg::*;
#(
  parameter logic [7:0] CRC_POLY = 8'h07,
  localparam int        IMG_W    = 8 * IMG_BYTES
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sdaIn,
  input  dpCtl_t           ctl,
  output logic [IMG_W-1:0] cfgImage,
  output logic [IMG_W-1:0] hwImage,
  output logic             devMissing,
  output logic             crcBad
);

  logic [7:0] imgReg [IMG_BYTES];
  logic [7:0] rxShift;
  logic [7:0] crcAcc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < IMG_BYTES; i++) imgReg[i] <= '0;
      rxShift    <= '0;
      crcAcc     <= '0;
      devMissing <= 1'b0;
      crcBad     <= 1'b0;
    end else begin
      if (ctl.loadDefaults) begin
        for (int i = 0; i < IMG_BYTES; i++) imgReg[i] <= factoryByte(i);
        devMissing <= 1'b1;
      end
      if (ctl.shiftIn) rxShift <= {rxShift[6:0], sdaIn};
      if (ctl.storeByte) begin
        imgReg[ctl.byteIdx] <= rxShift;
        if (int'(ctl.byteIdx) < CRC_POS) crcAcc <= crcStep(crcAcc, rxShift, CRC_POLY);
        if (int'(ctl.byteIdx) == CRC_POS && rxShift != crcAcc) begin
          devMissing <= 1'b1;
          crcBad     <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < IMG_BYTES; g++) begin : g_bytes
    assign cfgImage[8*g +: 8] = imgReg[g];
    assign hwImage[8*g +: 8]  = factoryByte(g);
  end

endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader
  import eecfg_pkg::*;
#(
  parameter int         QTR_CYCLES = 4,
  parameter logic [6:0] DEV_ADDR   = 7'h50,
  parameter logic [7:0] CRC_POLY   = 8'h07
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclIn,
  output logic                   sclDrvLow,
  input  logic                   sdaIn,
  output logic                   sdaDrvLow,
  output logic [8*IMG_BYTES-1:0] cfgImage,
  output logic [8*IMG_BYTES-1:0] hwImage,
  output logic                   devMissing,
  output logic                   crcBad,
  output logic                   loadDone
);

  dpCtl_t ctl;

  eecfg_ctrl #(.QTR_CYCLES(QTR_CYCLES), .DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .sclDrvLow(sclDrvLow),
    .sdaDrvLow(sdaDrvLow),
    .ctl      (ctl),
    .loadDone (loadDone)
  );

  eecfg_dp #(.CRC_POLY(CRC_POLY)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sdaIn     (sdaIn),
    .ctl       (ctl),
    .cfgImage  (cfgImage),
    .hwImage   (hwImage),
    .devMissing(devMissing),
    .crcBad    (crcBad)
  );

endmodule

// File: rtl/eeprom_cfg_loader_chk.sv
module eeprom_cfg_loader_chk
  import eecfg_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   sclDrvLow,
  input logic                   sdaDrvLow,
  input logic [8*IMG_BYTES-1:0] cfgImage,
  input logic                   devMissing,
  input logic                   crcBad,
  input logic                   loadDone
);

  // R9: completion is sticky
  p_done_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> loadDone);

  // R9: image frozen once complete
  p_image_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> $stable(cfgImage));

  // R9: both lines released after completion
  p_lines_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |-> (!sclDrvLow && !sdaDrvLow));

  // R5: a CRC error always comes with the device-missing flag
  p_crc_with_missing_r5: assert property (@(posedge clk) disable iff (!rstN)
    crcBad |-> devMissing);

  // R5: flags never clear without reset
  p_missing_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    devMissing |=> devMissing);

  // R9: flags frozen once complete
  p_flags_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> ($stable(devMissing) && $stable(crcBad)));

endmodule

bind eeprom_cfg_loader eeprom_cfg_loader_chk u_chk (.*);

// File: tb/eeprom_cfg_loader_bench.sv
`timescale 1ns/1ps
module eeprom_cfg_loader_bench;

  localparam int NB = 18;
  localparam int IW = 8 * NB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic sclDrvLow, sdaDrvLow, devMissing, crcBad, loadDone;
  logic [IW-1:0] cfgImage, hwImage;
  logic benchSclLow = 1'b0, benchSdaLow = 1'b0, respLow;
  logic sclIn, sdaIn;

  assign sclIn = ~(sclDrvLow | benchSclLow);
  assign sdaIn = ~(sdaDrvLow | respLow | benchSdaLow);

  eeprom_cfg_loader #(.QTR_CYCLES(2)) u_eeprom_cfg_loader (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sclDrvLow(sclDrvLow),
    .sdaIn(sdaIn), .sdaDrvLow(sdaDrvLow), .cfgImage(cfgImage),
    .hwImage(hwImage), .devMissing(devMissing), .crcBad(crcBad),
    .loadDone(loadDone)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // behavioural EEPROM
  logic [7:0] rom [0:255];
  logic [6:0] respAddr = 7'h50;
  logic       prevScl = 1'b1, prevSda = 1'b1;
  logic [2:0] rState;
  logic [3:0] rBit;
  logic [7:0] shreg, ptr, wordAddr;
  logic       ackPh, mAck, nackSeen, stopSeen;
  int         bytesSent;
  int         sclActs;
  logic       prevDrv = 1'b0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    prevDrv <= sclDrvLow;
    if (sclDrvLow && !prevDrv) sclActs <= sclActs + 1;
    prevScl <= sclIn;
    prevSda <= sdaIn;
    if (!rstN) begin
      rState <= 3'd0; rBit <= 4'd0; respLow <= 1'b0; ackPh <= 1'b0; mAck <= 1'b0;
      nackSeen <= 1'b0; stopSeen <= 1'b0; bytesSent <= 0; ptr <= 8'h00;
      wordAddr <= 8'hFF; shreg <= 8'h00; sclActs <= 0;
    end else if (prevScl && sclIn && prevSda && !sdaIn) begin
      rState <= 3'd1; rBit <= 4'd0; ackPh <= 1'b0; respLow <= 1'b0;
    end else if (prevScl && sclIn && !prevSda && sdaIn) begin
      rState <= 3'd0; respLow <= 1'b0; stopSeen <= 1'b1;
    end else if (!prevScl && sclIn && rState != 3'd0 && rState != 3'd4) begin
      if (ackPh) begin
        if (rState == 3'd3) mAck <= !sdaIn;
      end else begin
        shreg <= {shreg[6:0], sdaIn};
        rBit  <= rBit + 4'd1;
      end
    end else if (prevScl && !sclIn && rState != 3'd0 && rState != 3'd4) begin
      if (ackPh) begin
        ackPh <= 1'b0;
        respLow <= 1'b0;
        case (rState)
          3'd1: begin
            rBit <= 4'd0;
            if (shreg[0]) begin rState <= 3'd3; respLow <= !rom[ptr][7]; end
            else rState <= 3'd2;
          end
          3'd2: begin ptr <= shreg; wordAddr <= shreg; rState <= 3'd4; end
          default: begin
            if (mAck) begin rBit <= 4'd0; respLow <= !rom[ptr][7]; end
            else begin rState <= 3'd0; nackSeen <= 1'b1; end
          end
        endcase
      end else if (rBit == 4'd8) begin
        rBit <= 4'd0;
        ackPh <= 1'b1;
        if (rState == 3'd3) begin
          respLow <= 1'b0; ptr <= ptr + 8'd1; bytesSent <= bytesSent + 1;
        end else if (rState == 3'd1 && shreg[7:1] != respAddr) begin
          rState <= 3'd0; respLow <= 1'b0; ackPh <= 1'b0;
        end else begin
          respLow <= 1'b1;
        end
      end else if (rState == 3'd3) begin
        respLow <= !rom[ptr][3'd7 - rBit[2:0]];
      end
    end
  end

  function automatic logic [7:0] refCrc();
    logic [7:0] c = 8'h00;
    for (int b = 0; b < 8; b++) begin
      for (int k = 7; k >= 0; k--) begin
        logic fb;
        fb = c[7] ^ rom[b][k];
        c = {c[6:0], 1'b0};
        if (fb) c = c ^ 8'h07;
      end
    end
    return c;
  endfunction

  function automatic logic [IW-1:0] factoryImg();
    logic [IW-1:0] v = '0;
    logic [7:0] f [0:8] = '{8'h4C, 8'h10, 8'h08, 8'h05, 8'h10, 8'h80, 8'h01, 8'h00, 8'h7A};
    for (int i = 0; i < 9; i++) v[8*i +: 8] = f[i];
    v[8*17 +: 8] = 8'h01;
    return v;
  endfunction

  function automatic logic [IW-1:0] romImg();
    logic [IW-1:0] v;
    for (int i = 0; i < NB; i++) v[8*i +: 8] = rom[i];
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [IW-1:0] act,
                       input logic [IW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fillRom(input bit corrupt);
    for (int i = 0; i < 256; i++) rom[i] = 8'($urandom);
    rom[8] = refCrc();
    if (corrupt) rom[8] = rom[8] ^ (8'h01 << ($urandom % 8));
  endtask

  task automatic doReset(input bit strapAbsent);
    rstN = 1'b0;
    benchSclLow = strapAbsent;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitDone();
    int guard = 0;
    while (!loadDone && guard < 30000) begin
      @(posedge clk);
      guard++;
    end
    @(negedge clk);
    check(loadDone, "R9 done timeout", IW'(loadDone), IW'(1));
  endtask

  task automatic readScenario(input bit corrupt, input string tag);
    fillRom(corrupt);
    respAddr = 7'h50;
    doReset(1'b0);
    waitDone();
    check(cfgImage == romImg(), {"R3 image ", tag}, cfgImage, romImg());
    check(wordAddr == 8'h00 && bytesSent == NB && nackSeen && stopSeen,
          {"R2 transaction ", tag}, IW'(bytesSent), IW'(NB));
    check(hwImage == factoryImg(), {"R8 hw image ", tag}, hwImage, factoryImg());
    if (corrupt)
      check(devMissing && crcBad, "R5 flags on bad crc", IW'({devMissing, crcBad}), IW'(2'b11));
    else
      check(!devMissing && !crcBad, {"R4 flags on good crc ", tag},
            IW'({devMissing, crcBad}), IW'(2'b00));
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) rom[i] = 8'h00;
    // R10 reset state
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!loadDone && !devMissing && !crcBad && !sclDrvLow && !sdaDrvLow,
          "R10 reset outputs", IW'({loadDone, devMissing, crcBad, sclDrvLow, sdaDrvLow}), '0);
    check(cfgImage == '0, "R10 reset image", cfgImage, '0);

    // R2 R3 R4: good images with random contents
    for (int n = 0; n < 3; n++) readScenario(1'b0, $sformatf("good%0d", n));

    // R5: corrupted check byte, data still loaded
    readScenario(1'b1, "badcrc");

    // R9: disturb the data line after done; nothing may move
    begin
      logic [IW-1:0] held;
      held = cfgImage;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        benchSdaLow = ~benchSdaLow;
      end
      benchSdaLow = 1'b0;
      repeat (3) @(negedge clk);
      check(cfgImage == held && devMissing && crcBad && loadDone && !sclDrvLow && !sdaDrvLow,
            "R9 outputs frozen", cfgImage, held);
    end

    // R6: device does not acknowledge
    fillRom(1'b0);
    respAddr = 7'h51;
    doReset(1'b0);
    waitDone();
    check(cfgImage == factoryImg(), "R6 defaults after nack", cfgImage, factoryImg());
    check(devMissing && !crcBad, "R6 flags after nack", IW'({devMissing, crcBad}), IW'(2'b10));
    check(bytesSent == 0 && stopSeen, "R6 no data read", IW'(bytesSent), '0);
    respAddr = 7'h50;

    // R1 R7: strap says absent
    fillRom(1'b0);
    doReset(1'b1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(loadDone, "R1 done two edges after release", IW'(loadDone), IW'(1));
    check(cfgImage == factoryImg(), "R7 factory image", cfgImage, factoryImg());
    check(devMissing && !crcBad, "R1 flags on strap", IW'({devMissing, crcBad}), IW'(2'b10));
    repeat (4) @(negedge clk);
    benchSclLow = 1'b0;
    repeat (20) @(negedge clk);
    check(sclActs == 0 && bytesSent == 0, "R1 no bus activity", IW'(sclActs), '0);
    check(hwImage == factoryImg(), "R8 hw image after strap", hwImage, factoryImg());

    // one more good read after the strap case
    readScenario(1'b0, "final");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles >= 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected<150000", cycles);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule